// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block computes the Montgomery product A·B·2^(−N) mod P for an odd N-bit modulus P and two operands that are both below P. After a start request it takes the operands, spends one cycle forming the sum B+P in a register, and then walks through A one bit per cycle from the least significant end. In each of those N cycles a single four-way choice adds 0, B, P or the stored B+P to a running total. The choice depends only on the low bit of the total, the current bit of A and the low bit of B. The total is then halved. No magnitude comparison happens inside the loop.

After the loop the total is below 2P. One final cycle subtracts P when the total is at least P. The block then raises `done` for a single cycle and drives the reduced result.

The control pins are plain pulses. There is no valid/ready stream at this edge: `start` is sampled only while the block is idle, and a caller tracks `busy`. Conversion into and out of the Montgomery domain belongs to the caller.

Top module: `mont_mul_serial`

## Requirements
- R1: While reset is held and after it is released, with no start, `busy`, `done` and `result` are all 0.
- R2: For an odd P, with A < P and B < P, the result delivered with `done` equals A·B·2^(−N) mod P, where N is the operand width (16 by default).
- R3: `done` is high for exactly one cycle. It rises on the (N+2)th rising edge after the edge that samples `start`. That is one precompute cycle, N iteration cycles and one final-subtraction cycle.
- R4: `busy` is high from the edge after `start` is sampled until the edge at which `done` rises. `busy` is low whenever `done` is high.
- R5: A `start` pulse arriving while `busy` is high is ignored. The operation in flight completes with its original operands, and no extra `done` follows.
- R6: `result` changes only at the edge where `done` rises. Otherwise it holds its value, even while the operand inputs change.
- R7: The result is always below P, including the cases where the loop total lands between P and 2P−1 and the final subtraction must act. Inside the loop the running total never reaches 2P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| a_in | input | N | Multiplier operand, below P |
| b_in | input | N | Multiplicand operand, below P |
| p_in | input | N | Odd modulus |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | N | A·B·2^(−N) mod P of the last completed operation |

## Verification
The hardest path to reach from the ports is the final subtraction. It acts only when the halving loop leaves a total between P and 2P−1, and that happens only for operands close to the modulus. The stimulus therefore includes operand pairs equal to P−1 against several moduli, a modulus of all ones, and tiny moduli such as 3 and 5. These sit alongside mixed-pattern and random operands, and every result is compared against a reference built from a brute-force inverse of 2^N mod P. A start pulse carrying different operands is injected mid-run to show that the running operation is not disturbed.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOOP = 2'd2,
    ST_FIN  = 2'd3
  } mm_state_e;
endpackage

// File: rtl/mont_addend_sel.sv
// Picks the value added to the running total in one iteration.
// The key is {total lsb, current multiplier bit, multiplicand lsb}.
module mont_addend_sel #(
  parameter int N = 16
) (
  input  logic         t_lsb,
  input  logic         a_bit,
  input  logic         b_lsb,
  input  logic [N-1:0] b_val,
  input  logic [N-1:0] p_val,
  input  logic [N:0]   bp_val,
  output logic [N:0]   addend
);
  always_comb begin
    unique case ({t_lsb, a_bit, b_lsb})
      3'b000, 3'b001: addend = '0;
      3'b010:         addend = {1'b0, b_val};
      3'b011:         addend = bp_val;
      3'b100, 3'b101: addend = {1'b0, p_val};
      3'b110:         addend = bp_val;
      default:        addend = {1'b0, b_val};
    endcase
  end
endmodule

// File: rtl/mont_step.sv
// One add-and-halve step. The sum is one bit wider than the total,
// so nothing is lost before the shift.
module mont_step #(
  parameter int N = 16
) (
  input  logic [N:0] t_cur,
  input  logic [N:0] addend,
  output logic [N:0] t_next
);
  localparam int SW = N + 2;
  logic [SW-1:0] sum;
  always_comb begin
    sum    = {1'b0, t_cur} + {1'b0, addend};
    t_next = sum[SW-1:1];
  end
endmodule

// File: rtl/mont_final_sub.sv
// Conditional subtraction: the loop total is below 2P, so one
// subtraction of P is enough to bring it below P.
module mont_final_sub #(
  parameter int N = 16
) (
  input  logic [N:0]   t_val,
  input  logic [N-1:0] p_val,
  output logic [N-1:0] r_val
);
  logic [N:0] diff;
  always_comb begin
    diff  = t_val - {1'b0, p_val};
    r_val = (t_val >= {1'b0, p_val}) ? diff[N-1:0] : t_val[N-1:0];
  end
endmodule

// File: rtl/mont_mul_serial.sv
module mont_mul_serial
  import mont_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic [N-1:0] p_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  mm_state_e   st;
  logic [N-1:0] a_q, b_q, p_q, res_q;
  logic [N:0]   bp_q, t_q, t_nxt, addend;
  logic [N-1:0] fin_val;
  logic [CW-1:0] cnt;
  logic         done_q;

  mont_addend_sel #(.N(N)) u_sel (
    .t_lsb (t_q[0]),
    .a_bit (a_q[0]),
    .b_lsb (b_q[0]),
    .b_val (b_q),
    .p_val (p_q),
    .bp_val(bp_q),
    .addend(addend)
  );

  mont_step #(.N(N)) u_step (
    .t_cur (t_q),
    .addend(addend),
    .t_next(t_nxt)
  );

  mont_final_sub #(.N(N)) u_fin (
    .t_val(t_q),
    .p_val(p_q),
    .r_val(fin_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      p_q    <= '0;
      bp_q   <= '0;
      t_q    <= '0;
      cnt    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          a_q <= a_in;
          b_q <= b_in;
          p_q <= p_in;
          t_q <= '0;
          cnt <= '0;
          st  <= ST_PRE;
        end
        ST_PRE: begin
          bp_q <= {1'b0, b_q} + {1'b0, p_q};
          st   <= ST_LOOP;
        end
        ST_LOOP: begin
          t_q <= t_nxt;
          a_q <= a_q >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_FIN;
        end
        default: begin
          res_q  <= fin_val;
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy   = (st != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] result,
  input logic [N-1:0] p_q,
  input logic [N:0]   t_q
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_BUSY_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(p_q)); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done); // R6

  AST_RESULT_BELOW_P: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < p_q)); // R7

  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && p_q[0]) |-> (t_q < {p_q, 1'b0})); // R7
endmodule

bind mont_mul_serial mont_mul_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result),
  .p_q   (p_q),
  .t_q   (t_q)
);

// File: tb/tb_mont_mul_serial.sv
`timescale 1ns/1ps
module tb_mont_mul_serial;
  localparam int W  = 16;
  localparam int NV = 14;
  localparam int NR = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, p_in = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mont_mul_serial #(.N(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .p_in(p_in),
    .busy(busy), .done(done), .result(result)
  );

  // {a, b, p}
  localparam logic [3*W-1:0] VEC [NV] = '{
    {16'd1,     16'd1,     16'd65521},
    {16'd0,     16'd12345, 16'd65521},
    {16'd65520, 16'd65520, 16'd65521},
    {16'd12345, 16'd54321, 16'd65521},
    {16'd2,     16'd2,     16'd3},
    {16'd1,     16'd0,     16'd3},
    {16'd4660,  16'd22136, 16'd40961},
    {16'd65534, 16'd65534, 16'd65535},
    {16'd32767, 16'd32768, 16'd65535},
    {16'd1,     16'd2,     16'd5},
    {16'd100,   16'd200,   16'd257},
    {16'd255,   16'd254,   16'd257},
    {16'd40000, 16'd40001, 16'd65535},
    {16'd7,     16'd9,     16'd11}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned ref_mont(input longint unsigned a, b, p);
    longint unsigned r2, rinv, x;
    bit found;
    r2 = (64'd1 << W) % p;
    rinv = 0;
    found = 0;
    for (longint unsigned k = 0; k < p && !found; k++)
      if ((k * r2) % p == 1) begin
        rinv = k;
        found = 1;
      end
    x = (a * b) % p;
    return (x * rinv) % p;
  endfunction

  task automatic run_op(input logic [W-1:0] a, b, p, input bit inject);
    longint unsigned exp;
    int cyc;
    bit seen;
    exp = ref_mont(a, b, p);
    @(negedge clk);
    a_in = a; b_in = b; p_in = p; start = 1'b1;
    cyc = 0;
    seen = 0;
    while (!seen && cyc < 100) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (cyc == 1) chk(busy === 1'b1, "R4 busy after start", longint'(busy), 1);
      if (inject && cyc == 5) begin
        a_in = ~a; b_in = 16'd1; p_in = 16'd7; start = 1'b1;
      end
      if (done === 1'b1) seen = 1;
    end
    chk(cyc == W + 3, "R3 done latency", cyc, W + 3);
    chk(result == exp[W-1:0], "R2 product", longint'(result), longint'(exp));
    chk(result < p, "R7 below modulus", longint'(result), longint'(p));
    chk(busy === 1'b0, "R4 busy low at done", longint'(busy), 0);
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R3 single-cycle done", longint'(done), 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    int extra;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === '0, "R1 reset state",
        longint'({busy, done, result}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === '0, "R1 idle after reset",
        longint'({busy, done, result}), 0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);

    for (int i = 0; i < NR; i++) begin
      logic [W-1:0] p, a, b;
      p = W'($urandom) | 16'd1;
      if (p < 3) p = 16'd3;
      a = W'($urandom % p);
      b = W'($urandom % p);
      run_op(a, b, p, 1'b0);
    end

    // R5: start during busy with other operands is ignored
    run_op(16'd3, 16'd5, 16'd65521, 1'b1);
    extra = 0;
    for (int k = 0; k < W + 6; k++) begin
      @(negedge clk);
      if (done === 1'b1) extra++;
    end
    chk(extra == 0, "R5 no extra done", extra, 0);

    // R6: result holds while inputs move without start
    held = result;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      a_in = W'($urandom); b_in = W'($urandom); p_in = W'($urandom);
    end
    @(negedge clk);
    chk(result == held && busy === 1'b0, "R6 result held", longint'(result), longint'(held));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule